// File: doc/BRIEF.md
# BCD Calendar Counter with Minute Alarm

This block keeps wall-clock time for a chip that already produces a one-clock pulse once per second. Seconds, minutes and hours are held in packed BCD, so software can print them without converting. The date is a plain 16-bit binary count of elapsed days, and turning it into a calendar date is left to software. All state sits behind a byte-wide register file with 8-bit addresses. A control byte starts and stops the count, arms the alarm fields and enables the interrupt.

The alarm matches on minute, hour and day. Each of the three has its own enable, and there is no seconds field. The alarm is checked once each time the seconds wrap from 59 to 00. If every enabled field equals the new time, a sticky flag is set, and the flag drives the interrupt output when interrupts are enabled. Software clears the flag by writing 1 to its bit. A busy bit in the control byte shows the cycle in which the counters step, so software knows when a read may see a value that is changing.

Top module: `bcd_cal_alarm`

## Requirements
- R1: While bit 0 (run) of the control byte is 1, every cycle with `sec_tick` high advances the seconds register (address 0x15) by one in packed BCD, from 00 to 59. A wrap from 59 to 00 advances the minutes register (0x16), which also counts 00 to 59 in BCD.
- R2: The hours register (0x17) counts 00 to 23 in BCD and advances when the minutes wrap. A wrap from 23:59:59 gives 00:00:00 and adds one to the 16-bit binary day count, which is split into a low byte (0x18) and a high byte (0x19). The day count wraps from 0xFFFF to 0x0000.
- R3: The registers are control 0x14, seconds 0x15, minutes 0x16, hours 0x17, day low 0x18, day high 0x19, alarm minute 0x1A, alarm hour 0x1B, alarm day low 0x1C and alarm day high 0x1D. `rd_data` is registered. It shows the register addressed in the previous cycle, as that register stood in that cycle. Every other address reads 0x00.
- R4: The control byte holds busy (bit 7), day-alarm enable (bit 5), hour-alarm enable (bit 4), minute-alarm enable (bit 3), alarm flag (bit 2), interrupt enable (bit 1) and run (bit 0). Bit 6 reads 0. Busy reads 1 when the control byte was addressed in a cycle with `sec_tick` high, and writes to bits 7 and 6 are ignored.
- R5: With run at 0, ticks leave every time and day register unchanged. Writing run back to 1 resumes counting from the held value.
- R6: When a time register is written in the same cycle as a counting tick, the written value is stored in that register. The fields that are not written still advance.
- R7: The alarm is checked only in a cycle where the seconds wrap from 59 to 00. It is checked against the new minute, hour and day. The flag is set when every enabled field matches, and a field whose enable is 0 is ignored. With no field enabled, every wrap sets the flag.
- R8: Writing the control byte with bit 2 at 1 clears the alarm flag, and writing bit 2 at 0 leaves it unchanged. If an alarm match and a clear fall in the same cycle, the match wins.
- R9: `irq` is high exactly when the alarm flag and the interrupt enable are both 1. It is updated on the same clock edge as the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears all registers |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register address for reads and writes |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data for the previous cycle's address |
| irq | output | 1 | Alarm interrupt, registered |

## Verification
A tick or a write presented in a cycle takes effect at the next rising edge. A read needs one more edge, because the bench sets the address on a falling edge and samples `rd_data` on the following falling edge. `irq` and the flag change on the same edge as the counters, so the bench samples `irq` on the falling edge straight after the tick. Busy is checked by presenting the control address together with the tick and reading bit 7 one edge later.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 8;
  localparam int DAY_W  = 2 * DATA_W;
  localparam int NFLD   = 3;  // seconds, minutes, hours

  localparam logic [ADDR_W-1:0] A_CTRL  = 8'h14;
  localparam logic [ADDR_W-1:0] A_SEC   = 8'h15;
  localparam logic [ADDR_W-1:0] A_MIN   = 8'h16;
  localparam logic [ADDR_W-1:0] A_HOUR  = 8'h17;
  localparam logic [ADDR_W-1:0] A_DAYL  = 8'h18;
  localparam logic [ADDR_W-1:0] A_DAYH  = 8'h19;
  localparam logic [ADDR_W-1:0] A_AMIN  = 8'h1A;
  localparam logic [ADDR_W-1:0] A_AHOUR = 8'h1B;
  localparam logic [ADDR_W-1:0] A_ADAYL = 8'h1C;
  localparam logic [ADDR_W-1:0] A_ADAYH = 8'h1D;

  localparam int B_BUSY = 7;
  localparam int B_DAE  = 5;
  localparam int B_HAE  = 4;
  localparam int B_MAE  = 3;
  localparam int B_FLAG = 2;
  localparam int B_AIE  = 1;
  localparam int B_RUN  = 0;
endpackage

// File: rtl/cal_bcd_step.sv
module cal_bcd_step #(
  parameter int          W     = 8,
  parameter logic [7:0]  LIMIT = 8'h59
) (
  input  logic [W-1:0] cur,
  output logic [W-1:0] nxt,
  output logic         wrap
);
  always_comb begin
    wrap = (cur == LIMIT);
    if (wrap)
      nxt = '0;
    else if (cur[3:0] == 4'h9)
      nxt = {cur[7:4] + 4'h1, 4'h0};
    else
      nxt = {cur[7:4], cur[3:0] + 4'h1};
  end
endmodule

// File: rtl/cal_time_core.sv
module cal_time_core
  import rtc_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] sec,
  output logic [DATA_W-1:0] min,
  output logic [DATA_W-1:0] hour,
  output logic [DAY_W-1:0]  day,
  output logic [DATA_W-1:0] nxt_min,
  output logic [DATA_W-1:0] nxt_hour,
  output logic [DAY_W-1:0]  nxt_day,
  output logic              roll
);
  logic [DATA_W-1:0] fld_q  [NFLD];
  logic [DATA_W-1:0] fld_nx [NFLD];
  logic [DATA_W-1:0] fld_d  [NFLD];
  logic              fld_wr [NFLD];
  logic [NFLD:0]     adv;
  logic [DAY_W-1:0]  day_q, day_d;

  assign adv[0] = step;

  for (genvar g = 0; g < NFLD; g++) begin : g_fld
    cal_bcd_step #(.W(DATA_W), .LIMIT((g == NFLD-1) ? 8'h23 : 8'h59)) u_step (
      .cur  (fld_q[g]),
      .nxt  (fld_nx[g]),
      .wrap (fld_wr[g])
    );
    assign adv[g+1] = adv[g] & fld_wr[g];

    always_comb begin
      fld_d[g] = adv[g] ? fld_nx[g] : fld_q[g];
      if (wr_en && addr == A_SEC + ADDR_W'(g))
        fld_d[g] = wr_data;
    end

    always_ff @(posedge clk) begin
      if (rst) fld_q[g] <= '0;
      else     fld_q[g] <= fld_d[g];
    end
  end

  always_comb begin
    day_d = adv[NFLD] ? day_q + DAY_W'(1) : day_q;
    if (wr_en && addr == A_DAYL) day_d[DATA_W-1:0]     = wr_data;
    if (wr_en && addr == A_DAYH) day_d[DAY_W-1:DATA_W] = wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) day_q <= '0;
    else     day_q <= day_d;
  end

  assign sec      = fld_q[0];
  assign min      = fld_q[1];
  assign hour     = fld_q[2];
  assign day      = day_q;
  assign nxt_min  = fld_d[1];
  assign nxt_hour = fld_d[2];
  assign nxt_day  = day_d;
  assign roll     = adv[1];

  // R5: no tick and no write keeps all time state
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!step && !wr_en) |=> ($stable(sec) && $stable(min) && $stable(hour) && $stable(day)));

  // R1: a plain ones-digit step adds one
  assert_sec_step_R1: assert property (@(posedge clk) disable iff (rst)
    (step && !wr_en && sec[3:0] < 4'h9) |=> (sec == $past(sec) + 8'h01));

  // R2: full-day wrap clears time and bumps the day
  assert_day_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (step && !wr_en && sec == 8'h59 && min == 8'h59 && hour == 8'h23)
      |=> (sec == 8'h00 && min == 8'h00 && hour == 8'h00 && day == $past(day) + DAY_W'(1)));
endmodule

// File: rtl/cal_alarm_unit.sv
module cal_alarm_unit
  import rtc_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              roll,
  input  logic [DATA_W-1:0] nxt_min,
  input  logic [DATA_W-1:0] nxt_hour,
  input  logic [DAY_W-1:0]  nxt_day,
  output logic              run,
  output logic [5:0]        ctrl_lo,
  output logic [DATA_W-1:0] al_min,
  output logic [DATA_W-1:0] al_hour,
  output logic [DAY_W-1:0]  al_day,
  output logic              irq
);
  logic dae, hae, mae, aie, flag;
  logic dae_d, hae_d, mae_d, aie_d, run_d, flag_d;
  logic ctrl_wr, hit;

  assign ctrl_wr = wr_en && addr == A_CTRL;

  always_comb begin
    hit = roll
        && (!mae || al_min  == nxt_min)
        && (!hae || al_hour == nxt_hour)
        && (!dae || al_day  == nxt_day);
    {dae_d, hae_d, mae_d, aie_d, run_d} = {dae, hae, mae, aie, run};
    if (ctrl_wr)
      {dae_d, hae_d, mae_d, aie_d, run_d} =
        {wr_data[B_DAE], wr_data[B_HAE], wr_data[B_MAE], wr_data[B_AIE], wr_data[B_RUN]};
    flag_d = hit | (flag & ~(ctrl_wr & wr_data[B_FLAG]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      {dae, hae, mae, aie, run, flag, irq} <= '0;
      al_min  <= '0;
      al_hour <= '0;
      al_day  <= '0;
    end else begin
      {dae, hae, mae, aie, run} <= {dae_d, hae_d, mae_d, aie_d, run_d};
      flag <= flag_d;
      irq  <= flag_d & aie_d;
      if (wr_en && addr == A_AMIN)  al_min  <= wr_data;
      if (wr_en && addr == A_AHOUR) al_hour <= wr_data;
      if (wr_en && addr == A_ADAYL) al_day[DATA_W-1:0]     <= wr_data;
      if (wr_en && addr == A_ADAYH) al_day[DAY_W-1:DATA_W] <= wr_data;
    end
  end

  assign ctrl_lo = {dae, hae, mae, flag, aie, run};

  // R7: the flag only rises after a seconds wrap
  assert_flag_src_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(roll));

  // R8: a clear with no wrap leaves the flag low
  assert_w1c_R8: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && wr_data[B_FLAG] && !roll) |=> !flag);

  // R9: interrupt never without flag and enable
  assert_irq_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> (flag && aie));
endmodule

// File: rtl/bcd_cal_alarm.sv
module bcd_cal_alarm
  import rtc_cal_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sec_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  logic [DATA_W-1:0] sec, min, hour, nxt_min, nxt_hour, al_min, al_hour;
  logic [DAY_W-1:0]  day, nxt_day, al_day;
  logic              run, roll;
  logic [5:0]        ctrl_lo;

  cal_time_core u_time (
    .clk, .rst,
    .step     (sec_tick & run),
    .wr_en, .addr, .wr_data,
    .sec, .min, .hour, .day,
    .nxt_min, .nxt_hour, .nxt_day, .roll
  );

  cal_alarm_unit u_alarm (
    .clk, .rst, .wr_en, .addr, .wr_data,
    .roll, .nxt_min, .nxt_hour, .nxt_day,
    .run, .ctrl_lo, .al_min, .al_hour, .al_day, .irq
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (addr)
        A_CTRL:  rd_data <= {sec_tick, 1'b0, ctrl_lo};
        A_SEC:   rd_data <= sec;
        A_MIN:   rd_data <= min;
        A_HOUR:  rd_data <= hour;
        A_DAYL:  rd_data <= day[DATA_W-1:0];
        A_DAYH:  rd_data <= day[DAY_W-1:DATA_W];
        A_AMIN:  rd_data <= al_min;
        A_AHOUR: rd_data <= al_hour;
        A_ADAYL: rd_data <= al_day[DATA_W-1:0];
        A_ADAYH: rd_data <= al_day[DAY_W-1:DATA_W];
        default: rd_data <= '0;
      endcase
    end
  end

  // R4: control read in a tick cycle shows busy
  assert_busy_R4: assert property (@(posedge clk) disable iff (rst)
    (addr == A_CTRL && sec_tick) |=> rd_data[B_BUSY]);

  // R3: unmapped addresses read zero
  assert_unmapped_R3: assert property (@(posedge clk) disable iff (rst)
    (addr < A_CTRL || addr > A_ADAYH) |=> (rd_data == '0));
endmodule

// File: tb/tb_bcd_cal_alarm.sv
`timescale 1ns/1ps
module tb_bcd_cal_alarm;
  logic clk = 0, rst = 1, sec_tick = 0, wr_en = 0, irq;
  logic [7:0] addr = 0, wr_data = 0, rd_data;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  bcd_cal_alarm dut (.clk, .rst, .sec_tick, .wr_en, .addr, .wr_data, .rd_data, .irq);

  always #5 clk = ~clk;

  // bench model
  logic [7:0] m_sec, m_min, m_hour, m_amin, m_ahour;
  logic [15:0] m_day, m_aday;
  bit m_run, m_aie, m_mae, m_hae, m_dae, m_flag;

  function automatic logic [7:0] to_bcd(int b);
    return {4'(b / 10), 4'(b % 10)};
  endfunction
  function automatic logic [7:0] bcd_next(logic [7:0] v, int lim);
    int b;
    b = int'(v[7:4]) * 10 + int'(v[3:0]) + 1;
    if (b > lim) b = 0;
    return to_bcd(b);
  endfunction

  task automatic model_advance();
    bit c1, c2, c3;
    if (!m_run) return;
    c1 = (m_sec == 8'h59);
    c2 = c1 && (m_min == 8'h59);
    c3 = c2 && (m_hour == 8'h23);
    m_sec = bcd_next(m_sec, 59);
    if (c1) m_min = bcd_next(m_min, 59);
    if (c2) m_hour = bcd_next(m_hour, 23);
    if (c3) m_day = m_day + 16'd1;
    if (c1 && (!m_mae || m_amin == m_min) && (!m_hae || m_ahour == m_hour)
           && (!m_dae || m_aday == m_day))
      m_flag = 1;
  endtask

  task automatic model_write(logic [7:0] a, logic [7:0] d);
    case (a)
      8'h14: begin
        {m_dae, m_hae, m_mae, m_aie, m_run} = {d[5], d[4], d[3], d[1], d[0]};
        if (d[2]) m_flag = 0;
      end
      8'h15: m_sec = d;
      8'h16: m_min = d;
      8'h17: m_hour = d;
      8'h18: m_day[7:0] = d;
      8'h19: m_day[15:8] = d;
      8'h1A: m_amin = d;
      8'h1B: m_ahour = d;
      8'h1C: m_aday[7:0] = d;
      8'h1D: m_aday[15:8] = d;
      default: ;
    endcase
  endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
    model_write(a, d);
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] v);
    @(negedge clk); addr = a;
    @(negedge clk); v = rd_data;
  endtask

  task automatic tick();
    @(negedge clk); sec_tick = 1;
    @(negedge clk); sec_tick = 0;
    model_advance();
  endtask

  task automatic set_time(logic [7:0] h, logic [7:0] m, logic [7:0] s, logic [15:0] d);
    wr(8'h15, s); wr(8'h16, m); wr(8'h17, h); wr(8'h18, d[7:0]); wr(8'h19, d[15:8]);
  endtask

  task automatic check_time(string req);
    logic [7:0] v, v2;
    rd(8'h15, v); chk({req, " sec"}, 16'(v), 16'(m_sec));
    rd(8'h16, v); chk({req, " min"}, 16'(v), 16'(m_min));
    rd(8'h17, v); chk({req, " hour"}, 16'(v), 16'(m_hour));
    rd(8'h18, v); rd(8'h19, v2); chk({req, " day"}, {v2, v}, m_day);
  endtask

  function automatic logic [7:0] m_ctrl();
    return {2'b00, m_dae, m_hae, m_mae, m_flag, m_aie, m_run};
  endfunction

  initial begin
    #1_500_000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int seed, nt;
    m_sec = 0; m_min = 0; m_hour = 0; m_day = 0; m_amin = 0; m_ahour = 0; m_aday = 0;
    {m_run, m_aie, m_mae, m_hae, m_dae, m_flag} = '0;
    repeat (3) @(negedge clk);
    rst = 0;

    // reset state
    rd(8'h14, v); chk("R4 reset ctrl", 16'(v), 16'h00);
    check_time("R3 reset");
    chk("R9 reset irq", 16'(irq), 16'h0);

    // R5: stopped counter ignores ticks
    set_time(8'h05, 8'h10, 8'h20, 16'h0042);
    tick(); tick();
    check_time("R5 stopped");
    wr(8'h14, 8'h81);
    rd(8'h14, v); chk("R4 busy/bit7 write ignored", 16'(v), 16'h01);
    tick();
    check_time("R5 resumed");

    // R1 carry
    set_time(8'h07, 8'h09, 8'h59, 16'h0010);
    tick(); check_time("R1 minute carry");
    set_time(8'h09, 8'h59, 8'h59, 16'h0010);
    tick(); check_time("R2 hour carry");

    // R2 day wrap
    set_time(8'h23, 8'h59, 8'h59, 16'hFFFF);
    tick(); check_time("R2 day wrap");
    set_time(8'h23, 8'h59, 8'h59, 16'h00FF);
    tick(); check_time("R2 day byte carry");

    // R3 unmapped
    rd(8'h13, v); chk("R3 unmapped 0x13", 16'(v), 16'h00);
    rd(8'h20, v); chk("R3 unmapped 0x20", 16'(v), 16'h00);
    wr(8'h1A, 8'h33); wr(8'h1B, 8'h12); wr(8'h1C, 8'hAB); wr(8'h1D, 8'hCD);
    rd(8'h1A, v); chk("R3 alarm min", 16'(v), 16'h33);
    rd(8'h1B, v); chk("R3 alarm hour", 16'(v), 16'h12);
    rd(8'h1C, v); chk("R3 alarm day lo", 16'(v), 16'hAB);
    rd(8'h1D, v); chk("R3 alarm day hi", 16'(v), 16'hCD);

    // R4 busy during tick
    @(negedge clk); sec_tick = 1; addr = 8'h14;
    @(negedge clk); sec_tick = 0; model_advance();
    chk("R4 busy bit", 16'(rd_data[7]), 16'h1);

    // R6 write beats tick
    set_time(8'h11, 8'h22, 8'h30, 16'h0005);
    @(negedge clk); sec_tick = 1; wr_en = 1; addr = 8'h15; wr_data = 8'h42;
    @(negedge clk); sec_tick = 0; wr_en = 0;
    model_advance(); model_write(8'h15, 8'h42);
    check_time("R6 write priority");
    @(negedge clk); sec_tick = 1; wr_en = 1; addr = 8'h17; wr_data = 8'h04;
    @(negedge clk); sec_tick = 0; wr_en = 0;
    model_advance(); model_write(8'h17, 8'h04);
    check_time("R6 other field advances");

    // R7 full match
    set_time(8'h10, 8'h14, 8'h59, 16'h0123);
    wr(8'h1A, 8'h15); wr(8'h1B, 8'h10); wr(8'h1C, 8'h23); wr(8'h1D, 8'h01);
    wr(8'h14, 8'h3B);
    tick();
    chk("R7 flag on match", 16'(m_flag), 16'h1);
    chk("R9 irq on match", 16'(irq), 16'h1);
    rd(8'h14, v); chk("R7 ctrl flag", 16'(v), 16'(m_ctrl()));
    // R8
    wr(8'h14, 8'h3B);
    rd(8'h14, v); chk("R8 write0 keeps flag", 16'(v), 16'h3F);
    wr(8'h14, 8'h3F);
    rd(8'h14, v); chk("R8 write1 clears flag", 16'(v), 16'h3B);
    chk("R9 irq cleared", 16'(irq), 16'h0);

    // R7 minute mismatch blocks; hour-only enabled matches
    set_time(8'h10, 8'h20, 8'h59, 16'h0123);
    tick();
    rd(8'h14, v); chk("R7 mismatch no flag", 16'(v), 16'h3B);
    set_time(8'h10, 8'h20, 8'h59, 16'h0999);
    wr(8'h14, 8'h13);
    tick();
    rd(8'h14, v); chk("R7 disabled fields ignored", 16'(v), 16'h17);
    chk("R9 irq hour-only", 16'(irq), 16'h1);
    // R9 aie off: flag stays, irq low
    wr(8'h14, 8'h11);
    chk("R9 irq masked", 16'(irq), 16'h0);
    rd(8'h14, v); chk("R9 flag kept when masked", 16'(v), 16'h15);
    // R8 match and clear same cycle: match wins
    set_time(8'h10, 8'h20, 8'h59, 16'h0000);
    wr(8'h14, 8'h05);
    @(negedge clk); sec_tick = 1; wr_en = 1; addr = 8'h14; wr_data = 8'h05;
    @(negedge clk); sec_tick = 0; wr_en = 0;
    model_write(8'h14, 8'h05); model_advance();
    rd(8'h14, v); chk("R8 set wins over clear", 16'(v), 16'h05);
    wr(8'h14, 8'h05);

    // random runs
    seed = $urandom(32'd7);
    wr(8'h14, 8'h01);
    for (int i = 0; i < 20; i++) begin
      set_time(to_bcd(int'($urandom % 24)), to_bcd(int'($urandom % 60)),
               to_bcd(int'($urandom % 60)), 16'($urandom));
      nt = 1 + int'($urandom % 130);
      for (int k = 0; k < nt; k++) tick();
      check_time("R1 R2 random");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule